// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store that sits next to a direct-mapped data cache and keeps lines that the cache has recently thrown out. Each slot holds one whole cache line and the full line address it belongs to. Every slot has its own tag register and comparator, so one lookup checks all slots in the same cycle.

The cache controller asks the buffer only after a miss in the main array. It drives `lookup_valid_i` and `lookup_addr_i`, and in the same cycle it presents the line that the main array would displace on `evict_*`. On a buffer hit the controller takes the line from `vc_line_data_o` into the main array and sends no request to the next level. At the following clock edge the displaced line takes over the slot that was hit. On a buffer miss the controller goes to the next level, and the displaced line is written into the slot at the replacement pointer. That pointer walks the slots in ring order, so a full buffer loses the line that was inserted first.

Top module: `victim_buf`

## Requirements
- R1: After reset every slot is invalid. No lookup hits, `vc_line_data_o` is zero and `swap_done_o` is low.
- R2: When `lookup_valid_i` is high and `lookup_addr_i` equals the stored address of a valid slot, `vc_hit_o` is high in that same cycle and `vc_line_data_o` carries that slot's line.
- R3: When `lookup_valid_i` is low, `vc_hit_o` is low. Whenever `vc_hit_o` is low, `vc_line_data_o` is all zeros.
- R4: When `evict_valid_i` is high in a cycle with no buffer hit, the evicted address and line are stored at the next clock edge. From the following cycle a lookup of that address hits and returns that line.
- R5: When a hit and `evict_valid_i` occur in the same cycle, the hit slot takes the evicted address and line at the next edge. From then on the old address misses and the evicted address hits.
- R6: A hit with `evict_valid_i` low frees the hit slot at the next edge, because the line has moved back to the main array. A later lookup of that address misses.
- R7: `swap_done_o` is high for exactly one cycle, in the cycle after each cycle in which `vc_hit_o` is high.
- R8: Insertions without a hit fill slots in ring order, starting at slot 0 after reset. With four slots, the fifth insertion overwrites the first line inserted and keeps the other three.
- R9: A match needs the full line address (tag and index). Two addresses that share the index bits but differ in the tag bits do not match.
- R10: A swap writes in place and does not move the replacement pointer. The next plain insertion overwrites the slot it would have overwritten if the swap had not taken place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Probe the buffer after a main-array miss |
| lookup_addr_i | input | ADDR_W | Line address being probed |
| evict_valid_i | input | 1 | A line is displaced from the main array this cycle |
| evict_addr_i | input | ADDR_W | Line address of the displaced line |
| evict_data_i | input | LINE_W | Data of the displaced line |
| vc_hit_o | output | 1 | Probe matched a valid slot (combinational) |
| vc_line_data_o | output | LINE_W | Line from the matching slot, zero on a miss |
| swap_done_o | output | 1 | One-cycle pulse after a hit, once the slot has been updated |

## Verification
The bench fills the buffer, swaps a line into the middle slot and then inserts once more. A design that advances the ring pointer on a swap would overwrite the wrong slot, and the expected line would be missing. It probes an address that differs from a stored one only in its tag bits, which a design that compares only the index would report as a hit. It also takes a hit with no displaced line and later probes that address again; a design that leaves the slot valid would return a line that the main array now owns. Probes with `lookup_valid_i` low catch a design that hits without a request, and the `swap_done_o` checks catch a pulse that is missing, arrives late or lasts too long.

// File: rtl/vb_pkg.sv
package vb_pkg;
  parameter int unsigned VB_ENTRIES = 4;
  parameter int unsigned VB_ADDR_W  = 26;
  parameter int unsigned VB_LINE_W  = 128;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vb_entry.sv
module vb_entry #(
  parameter int unsigned AW = 26,
  parameter int unsigned DW = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          clr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] cmp_addr_i,
  output logic          match_o,
  output logic [DW-1:0] data_o
);
  logic          vld_q;
  logic [AW-1:0] tag_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= 1'b0;
    else if (wr_en_i) vld_q <= 1'b1;
    else if (clr_i)   vld_q <= 1'b0;
  end

  // tag and data need no reset; the valid bit guards them
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q <= wr_addr_i;
      dat_q <= wr_data_i;
    end
  end

  assign match_o = vld_q && (tag_q == cmp_addr_i);
  assign data_o  = dat_q;
endmodule

// File: rtl/vb_pick.sv
module vb_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 128
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][DW-1:0] data_i,
  output logic                 hit_o,
  output logic [N-1:0]         sel_o,
  output logic [DW-1:0]        data_o
);
  // lowest matching slot wins; duplicates are not expected
  always_comb begin
    logic found;
    found  = 1'b0;
    sel_o  = '0;
    data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        found    = 1'b1;
        sel_o[i] = 1'b1;
        data_o   = data_i[i];
      end
    end
    hit_o = found;
  end
endmodule

// File: rtl/vb_ring_ptr.sv
module vb_ring_ptr #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] ptr_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (adv_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int unsigned ENTRIES = vb_pkg::VB_ENTRIES,
  parameter int unsigned ADDR_W  = vb_pkg::VB_ADDR_W,
  parameter int unsigned LINE_W  = vb_pkg::VB_LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [LINE_W-1:0] evict_data_i,
  output logic              vc_hit_o,
  output logic [LINE_W-1:0] vc_line_data_o,
  output logic              swap_done_o
);
  localparam int unsigned IW = vb_pkg::idx_w(ENTRIES);

  logic [ENTRIES-1:0]             match_v, req_v, sel_v, wr_v, clr_v;
  logic [ENTRIES-1:0][LINE_W-1:0] data_v;
  logic [IW-1:0]                  ptr_q;
  logic                           hit, insert;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    vb_entry #(.AW(ADDR_W), .DW(LINE_W)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_v[g]),
      .clr_i      (clr_v[g]),
      .wr_addr_i  (evict_addr_i),
      .wr_data_i  (evict_data_i),
      .cmp_addr_i (lookup_addr_i),
      .match_o    (match_v[g]),
      .data_o     (data_v[g])
    );
  end

  assign req_v = match_v & {ENTRIES{lookup_valid_i}};

  vb_pick #(.N(ENTRIES), .DW(LINE_W)) u_pick (
    .req_i  (req_v),
    .data_i (data_v),
    .hit_o  (hit),
    .sel_o  (sel_v),
    .data_o (vc_line_data_o)
  );

  assign insert = evict_valid_i && !hit;

  // swap reuses the hit slot; plain insert takes the ring slot
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      wr_v[i]  = (sel_v[i] && evict_valid_i) || (insert && (ptr_q == IW'(i)));
      clr_v[i] = sel_v[i] && !evict_valid_i;
    end
  end

  vb_ring_ptr #(.N(ENTRIES), .IW(IW)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (insert),
    .ptr_o  (ptr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) swap_done_o <= 1'b0;
    else         swap_done_o <= hit;
  end

  assign vc_hit_o = hit;
endmodule

// File: rtl/vb_chk.sv
module vb_chk #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned LINE_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lookup_valid_i,
  input logic [ADDR_W-1:0] lookup_addr_i,
  input logic              evict_valid_i,
  input logic [ADDR_W-1:0] evict_addr_i,
  input logic [LINE_W-1:0] evict_data_i,
  input logic              vc_hit_o,
  input logic [LINE_W-1:0] vc_line_data_o,
  input logic              swap_done_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !vc_hit_o && !swap_done_o);

  assert_idle_no_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |-> !vc_hit_o);

  assert_miss_zero_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vc_hit_o |-> vc_line_data_o == '0);

  assert_insert_visible_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(evict_valid_i && !vc_hit_o) && lookup_valid_i &&
     lookup_addr_i == $past(evict_addr_i))
    |-> vc_hit_o && vc_line_data_o == $past(evict_data_i));

  // R5/R6: a line taken by a hit is gone from the buffer afterwards
  assert_hit_leaves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(vc_hit_o) && lookup_valid_i && lookup_addr_i == $past(lookup_addr_i) &&
     !($past(evict_valid_i) && lookup_addr_i == $past(evict_addr_i)))
    |-> !vc_hit_o);

  assert_pulse_after_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vc_hit_o |=> swap_done_o);

  assert_no_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vc_hit_o |=> !swap_done_o);
endmodule

bind victim_buf vb_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_vb_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .lookup_addr_i  (lookup_addr_i),
  .evict_valid_i  (evict_valid_i),
  .evict_addr_i   (evict_addr_i),
  .evict_data_i   (evict_data_i),
  .vc_hit_o       (vc_hit_o),
  .vc_line_data_o (vc_line_data_o),
  .swap_done_o    (swap_done_o)
);

// File: tb/victim_buf_test.sv
module victim_buf_test;
  localparam int AW = 26;
  localparam int DW = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lookup_valid_i = 1'b0;
  logic [AW-1:0] lookup_addr_i = '0;
  logic          evict_valid_i = 1'b0;
  logic [AW-1:0] evict_addr_i = '0;
  logic [DW-1:0] evict_data_i = '0;
  logic          vc_hit_o;
  logic [DW-1:0] vc_line_data_o;
  logic          swap_done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  victim_buf uut (.*);

  localparam logic [AW-1:0] A = 26'h0000040, B = 26'h0000080, C = 26'h00000C0,
                            D = 26'h0000100, E = 26'h0000140, F = 26'h0000180,
                            G = 26'h00001C0, H = 26'h0000200;

  function automatic logic [DW-1:0] mk(logic [AW-1:0] a);
    logic [31:0] w;
    w = {6'd0, a};
    return {w ^ 32'h1111_1111, w ^ 32'h2222_2222, w ^ 32'h3333_3333, w ^ 32'h4444_4444};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // probe without letting a clock edge see it
  task automatic probe(logic v, logic [AW-1:0] a, bit exp_hit, logic [DW-1:0] exp_d, string req);
    @(negedge clk_i);
    lookup_valid_i = v;
    lookup_addr_i  = a;
    #1;
    chk(vc_hit_o == exp_hit, req, DW'(vc_hit_o), DW'(exp_hit));
    chk(vc_line_data_o == exp_d, req, vc_line_data_o, exp_d);
    lookup_valid_i = 1'b0;
  endtask

  task automatic insert(logic [AW-1:0] a);
    @(negedge clk_i);
    evict_valid_i = 1'b1;
    evict_addr_i  = a;
    evict_data_i  = mk(a);
    @(negedge clk_i);
    evict_valid_i = 1'b0;
  endtask

  // hit on la; optionally hand in a displaced line ea
  task automatic take(logic [AW-1:0] la, bit ev, logic [AW-1:0] ea, string req);
    @(negedge clk_i);
    lookup_valid_i = 1'b1;
    lookup_addr_i  = la;
    evict_valid_i  = ev;
    evict_addr_i   = ea;
    evict_data_i   = mk(ea);
    #1;
    chk(vc_hit_o == 1'b1, req, DW'(vc_hit_o), DW'(1));
    chk(vc_line_data_o == mk(la), req, vc_line_data_o, mk(la));
    chk(swap_done_o == 1'b0, "R7 pulse early", DW'(swap_done_o), DW'(0));
    @(posedge clk_i); #1;
    chk(swap_done_o == 1'b1, "R7 pulse", DW'(swap_done_o), DW'(1));
    @(negedge clk_i);
    lookup_valid_i = 1'b0;
    evict_valid_i  = 1'b0;
    @(posedge clk_i); #1;
    chk(swap_done_o == 1'b0, "R7 pulse width", DW'(swap_done_o), DW'(0));
  endtask

  task automatic t_reset;
    probe(1'b1, A, 1'b0, '0, "R1 empty");
    probe(1'b1, '0, 1'b0, '0, "R1 zero addr");
    chk(swap_done_o == 1'b0, "R1 swap_done", DW'(swap_done_o), DW'(0));
  endtask

  task automatic t_fill;
    insert(A); insert(B); insert(C); insert(D);
    probe(1'b1, A, 1'b1, mk(A), "R4 A");
    probe(1'b1, B, 1'b1, mk(B), "R2 B");
    probe(1'b1, C, 1'b1, mk(C), "R2 C");
    probe(1'b1, D, 1'b1, mk(D), "R4 D");
    probe(1'b0, A, 1'b0, '0, "R3 no request");
  endtask

  task automatic t_alias;
    probe(1'b1, A | 26'h0100000, 1'b0, '0, "R9 tag differs");
    probe(1'b1, D | 26'h2000000, 1'b0, '0, "R9 top tag bit");
  endtask

  task automatic t_swap;
    take(C, 1'b1, E, "R5 swap hit");
    probe(1'b1, C, 1'b0, '0, "R5 old line gone");
    probe(1'b1, E, 1'b1, mk(E), "R5 new line in place");
  endtask

  task automatic t_ring;
    insert(F);
    probe(1'b1, A, 1'b0, '0, "R10 oldest replaced");
    probe(1'b1, F, 1'b1, mk(F), "R8 newest");
    probe(1'b1, B, 1'b1, mk(B), "R8 B kept");
    probe(1'b1, E, 1'b1, mk(E), "R10 swapped kept");
    probe(1'b1, D, 1'b1, mk(D), "R8 D kept");
  endtask

  task automatic t_move;
    take(B, 1'b0, '0, "R6 hit no victim");
    probe(1'b1, B, 1'b0, '0, "R6 slot freed");
    insert(G);
    insert(H);
    probe(1'b1, G, 1'b1, mk(G), "R8 G");
    probe(1'b1, H, 1'b1, mk(H), "R8 H");
    probe(1'b1, E, 1'b0, '0, "R8 E overwritten");
    probe(1'b1, D, 1'b1, mk(D), "R8 D kept");
    probe(1'b1, F, 1'b1, mk(F), "R8 F kept");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(vc_hit_o == 1'b0 && swap_done_o == 1'b0, "R1 in reset",
        DW'({vc_hit_o, swap_done_o}), DW'(0));
    rst_ni = 1'b1;
    t_reset;
    t_fill;
    t_alias;
    t_swap;
    t_ring;
    t_move;
    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule